// File: doc/BRIEF.md
# Bus Transmitter Enable Guard with Dominant Timeout

This block decides, cycle by cycle, whether a single-wire bus transmitter may drive the line. Transmit data uses the usual convention that 0 is dominant and 1 is recessive. The block combines three conditions to produce one enable:

- two control pins, an enable pin and a release pin, either of which switches the driver off at once;
- an arming rule tied to the operating mode;
- a protection timer that catches a transmit-data input stuck at dominant.

When the block is not enabled, the drive level it hands to the output stage is recessive, whatever the data.

The transmit-data input is brought into the clock domain by a two-flop synchroniser. The synchroniser resets to 1, so an undriven input reads as recessive, which gives the same result as a pull-up.

- **Arming:** after the block enters Normal mode, the driver is armed only once the synchronised data shows recessive. Leaving Normal mode disarms it, so the recessive check repeats on every entry.
- **Timeout:** a falling edge of the synchronised data starts the timer. If the data stays dominant for the parameterised number of cycles, the timeout flag sets and the driver turns off. Only a rising edge of the data clears the timer and the flag.

Top module: `txd_guard`

## Requirements
- R1: While `rst_n` is low and right after it is released, `drv_enable_o` is 0, `drv_level_o` is 1 and `dom_timeout_o` is 0.
- R2: Whenever `ctl_enable_i` is 0, `drv_enable_o` is 0 in the same cycle, without waiting for a clock edge.
- R3: Whenever `ctl_release_i` is 0, `drv_enable_o` is 0 in the same cycle, without waiting for a clock edge.
- R4: After `mode_normal_i` rises, `drv_enable_o` stays 0 until the synchronised data has been seen at 1. If the data is already 1, the enable rises at the first clock edge after `mode_normal_i` rises. If the data is 0 on entry, the enable rises at the third clock edge after `tx_data_i` goes to 1.
- R5: When `mode_normal_i` falls, `drv_enable_o` is 0 from the next clock edge on.
- R6: `drv_level_o` equals `tx_data_i` delayed by two clock edges while `drv_enable_o` is 1, and is 1 while `drv_enable_o` is 0.
- R7: If `tx_data_i` goes to 0 and stays there, `dom_timeout_o` is still 0 after TIMEOUT_CYC+2 clock edges and becomes 1 at clock edge TIMEOUT_CYC+3. From then on `drv_enable_o` is 0 and `drv_level_o` is 1.
- R8: A dominant pulse on `tx_data_i` that lasts fewer than TIMEOUT_CYC+1 cycles never sets `dom_timeout_o`.
- R9: Once `dom_timeout_o` is set, it clears at the third clock edge after `tx_data_i` returns to 1, and the enable then follows R2 to R5 again.
- R10: While `tx_data_i` stays 0, `dom_timeout_o` stays set, however long the data is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 1 | Transmit data, 0 = dominant; asynchronous |
| ctl_enable_i | input | 1 | Enable pin; 0 switches the driver off |
| ctl_release_i | input | 1 | Release pin; 0 switches the driver off |
| mode_normal_i | input | 1 | 1 while the device is in Normal mode |
| drv_enable_o | output | 1 | Transmitter may drive the bus |
| drv_level_o | output | 1 | Gated drive level, 1 = recessive |
| dom_timeout_o | output | 1 | Dominant timeout condition active |

## Verification
Each result has its own latency, and the checks sample on that latency:

| Result | Due |
|---|---|
| Effect of the control pins | Same cycle; checked one time unit after the inputs change |
| Data on `drv_level_o` | Two edges after the data changes |
| Arming on Normal entry, disarming on exit | One edge after the mode input changes |
| Timeout set | TIMEOUT_CYC+3 edges after a dominant start |
| Timeout clear | Three edges after the data returns to recessive |

The directed cases count edges exactly and sample on the falling clock edge, one edge before and one edge at each expected change. The random phase compares every output at each falling clock edge with a bench model. The model tracks the length of the dominant run and the arming state from the requirements.

// File: rtl/txd_guard.sv
module txd_guard #(
  parameter int unsigned TIMEOUT_CYC = 2000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_data_i,
  input  logic ctl_enable_i,
  input  logic ctl_release_i,
  input  logic mode_normal_i,
  output logic drv_enable_o,
  output logic drv_level_o,
  output logic dom_timeout_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic          txd_s, prev_q, armed_q, run_q, tmo_q;
  logic [CW-1:0] cnt_q;
  logic          fall, rise;

  assign txd_s = sync_q[SYNC_STAGES-1];
  assign fall  = prev_q & ~txd_s;
  assign rise  = ~prev_q & txd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], tx_data_i};
      prev_q <= txd_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              armed_q <= 1'b0;
    else if (!mode_normal_i) armed_q <= 1'b0;
    else if (txd_s)          armed_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (rise) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (fall) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q && !tmo_q) begin
      if (cnt_q == LAST) tmo_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign drv_enable_o  = armed_q & ctl_enable_i & ctl_release_i & ~tmo_q;
  assign drv_level_o   = drv_enable_o ? txd_s : 1'b1;
  assign dom_timeout_o = tmo_q;
endmodule

// File: rtl/txd_guard_chk.sv
module txd_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic ctl_enable_i,
  input logic ctl_release_i,
  input logic mode_normal_i,
  input logic drv_enable_o,
  input logic drv_level_o,
  input logic dom_timeout_o
);
  AST_ENABLE_PIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable_i |-> !drv_enable_o); // R2
  AST_RELEASE_PIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_release_i |-> !drv_enable_o); // R3
  AST_ARM_IN_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_enable_o) |-> $past(mode_normal_i)); // R4
  AST_EXIT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_normal_i) |=> !drv_enable_o); // R5
  AST_IDLE_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_enable_o |-> drv_level_o); // R6
  AST_TIMEOUT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    dom_timeout_o |-> (!drv_enable_o && drv_level_o)); // R7
endmodule

bind txd_guard txd_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_enable_i(ctl_enable_i),
  .ctl_release_i(ctl_release_i), .mode_normal_i(mode_normal_i),
  .drv_enable_o(drv_enable_o), .drv_level_o(drv_level_o),
  .dom_timeout_o(dom_timeout_o)
);

// File: tb/txd_guard_test.sv
`timescale 1ns/1ps
module txd_guard_test;
  localparam int unsigned T = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 1'b1, en = 1'b0, rel = 1'b0, nrm = 1'b0;
  logic drv_en, drv_lvl, tmo;
  int total = 0, bad = 0;

  txd_guard #(.TIMEOUT_CYC(T)) uut (
    .clk(clk), .rst_n(rst_n), .tx_data_i(txd), .ctl_enable_i(en),
    .ctl_release_i(rel), .mode_normal_i(nrm), .drv_enable_o(drv_en),
    .drv_level_o(drv_lvl), .dom_timeout_o(tmo)
  );

  always #2 clk = ~clk;

  // bench model: data delay line, dominant run length, arming
  logic m1 = 1'b1, m2 = 1'b1, m_arm = 1'b0;
  int   m_run = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= 1'b1; m2 <= 1'b1; m_run <= 0; m_arm <= 1'b0;
    end else begin
      m1 <= txd;
      m2 <= m1;
      m_run <= m2 ? 0 : ((m_run > int'(T)) ? m_run : m_run + 1);
      m_arm <= !nrm ? 1'b0 : (m2 ? 1'b1 : m_arm);
    end
  end

  function automatic logic exp_tmo();
    return m_run >= int'(T) + 1;
  endfunction
  function automatic logic exp_en();
    return m_arm & en & rel & ~exp_tmo();
  endfunction
  function automatic logic exp_lvl();
    return exp_en() ? m2 : 1'b1;
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog: got=running expected=finished");
    report();
  end

  initial begin
    tick(3);
    chk("R1 enable in reset", drv_en, 1'b0);
    chk("R1 level in reset", drv_lvl, 1'b1);
    chk("R1 timeout in reset", tmo, 1'b0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 enable after reset", drv_en, 1'b0);
    chk("R1 timeout after reset", tmo, 1'b0);

    en = 1'b1; rel = 1'b1; nrm = 1'b1;
    tick(1);
    chk("R4 armed with recessive data", drv_en, 1'b1);

    txd = 1'b0;
    tick(1);
    chk("R6 level one edge after data", drv_lvl, 1'b1);
    tick(1);
    chk("R6 level two edges after data", drv_lvl, 1'b0);
    tick(3);
    txd = 1'b1;
    tick(T + 4);
    chk("R8 short pulse no timeout", tmo, 1'b0);
    chk("R8 still enabled", drv_en, 1'b1);

    en = 1'b0; #1;
    chk("R2 enable pin off", drv_en, 1'b0);
    chk("R6 recessive while disabled", drv_lvl, 1'b1);
    en = 1'b1; #1;
    chk("R2 enable pin back", drv_en, 1'b1);
    rel = 1'b0; #1;
    chk("R3 release pin off", drv_en, 1'b0);
    rel = 1'b1; #1;
    chk("R3 release pin back", drv_en, 1'b1);
    @(negedge clk);

    nrm = 1'b0;
    tick(1);
    chk("R5 exit disarms", drv_en, 1'b0);
    txd = 1'b0;
    tick(2);
    nrm = 1'b1;
    tick(3);
    chk("R4 dominant on entry stays off", drv_en, 1'b0);
    txd = 1'b1;
    tick(2);
    chk("R4 not yet armed", drv_en, 1'b0);
    tick(1);
    chk("R4 armed after recessive", drv_en, 1'b1);
    tick(4);

    txd = 1'b0;
    tick(T + 2);
    chk("R7 timeout not yet", tmo, 1'b0);
    chk("R7 enable before timeout", drv_en, 1'b1);
    tick(1);
    chk("R7 timeout set", tmo, 1'b1);
    chk("R7 enable off", drv_en, 1'b0);
    chk("R7 level recessive", drv_lvl, 1'b1);
    tick(60);
    chk("R10 timeout held", tmo, 1'b1);
    txd = 1'b1;
    tick(2);
    chk("R9 timeout before clear", tmo, 1'b1);
    tick(1);
    chk("R9 timeout cleared", tmo, 1'b0);
    chk("R9 enable restored", drv_en, 1'b1);

    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(19, 0) == 0) txd = ~txd;
      if ($urandom_range(79, 0) == 0) en = ~en;
      if ($urandom_range(79, 0) == 0) rel = ~rel;
      if ($urandom_range(49, 0) == 0) nrm = ~nrm;
      tick(1);
      chk("R4/R5 random enable", drv_en, exp_en());
      chk("R6 random level", drv_lvl, exp_lvl());
      chk("R7/R9 random timeout", tmo, exp_tmo());
    end
    report();
  end
endmodule